// File: doc/BRIEF.md
# Integer Register ALU

This block is the execute stage arithmetic unit for a 32-bit integer core. One operation is accepted per clock. The caller supplies two source values and the instruction's func3 and func7 sub-fields. The caller can also select immediate mode, in which a 12-bit signed constant replaces the second register value. The opcode is fixed for this instruction class, so only the sub-fields pick the operation. Adding an operation later therefore needs only a new func code.

The result is registered. It appears on the cycle after the request, together with a valid flag. When no request is presented, the result register keeps its last value. The unit provides:
- add and subtract
- logical left shift, logical right shift and arithmetic right shift
- signed and unsigned set-less-than
- bitwise XOR, OR and AND

There is no left arithmetic shift, because it would produce the same result as the logical left shift.

Top module: `int_alu`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, out_valid_o is 0 and result_o is 0.
- R2: out_valid_o is 1 in exactly the cycles that follow a rising clock edge at which in_valid_i was 1.
- R3: When in_valid_i is 0 at a rising edge, result_o keeps its previous value.
- R4: With func3 = 000 in register mode, the result is rs1 + rs2 modulo 2^32 when func7 bit 5 is 0, and rs1 - rs2 modulo 2^32 when func7 bit 5 is 1.
- R5: func3 = 001 shifts rs1 left by the amount in the low 5 bits of the second operand, fills the vacated low bits with 0 and drops the bits shifted out at the top. An operand of 32 therefore shifts by 0.
- R6: func3 = 101 with func7 bit 5 = 0 shifts rs1 right by the low 5 bits of the second operand and fills the vacated high bits with 0.
- R7: func3 = 101 with func7 bit 5 = 1 shifts rs1 right by the low 5 bits of the second operand and fills the vacated high bits with copies of rs1 bit 31.
- R8: func3 = 010 gives 1 when rs1 < operand as two's-complement numbers and 0 otherwise. Bits 31..1 of this result are always 0.
- R9: func3 = 011 gives 1 when rs1 < operand as unsigned numbers and 0 otherwise.
- R10: func3 = 100, 110 and 111 give the bitwise XOR, OR and AND of rs1 and the operand.
- R11: When use_imm_i is 1, the second operand is imm_i (range -2048 to 2047) sign-extended to 32 bits, and rs2_i has no effect. With func3 = 000, immediate mode always adds, whatever func7 bit 5 is.
- R12: func7 bits other than bit 5 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; captures the result at this edge |
| func3_i | input | 3 | Operation select |
| func7_i | input | 7 | Variant select; only bit 5 is used |
| use_imm_i | input | 1 | 1 selects the sign-extended immediate as the second operand |
| rs1_i | input | 32 | First source value |
| rs2_i | input | 32 | Second source value in register mode |
| imm_i | input | 12 | Signed immediate |
| result_o | output | 32 | Registered result |
| out_valid_o | output | 1 | Result valid, one cycle after the request |

## Verification
Two things can happen in the same clock edge: a new request is captured while the result of the previous request is still being presented. A request can also coincide with a gap, where the held value must survive. The bench provokes both with directed corner values and a long stream of random operations at random issue density, including many fully back-to-back runs. It judges every cycle against a behavioural model that predicts both the valid flag and the result. In immediate cases the model also drives conflicting rs2 and func7 values to show they have no effect.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [2:0] {
    F3_ADDSUB = 3'b000,
    F3_SLL    = 3'b001,
    F3_SLT    = 3'b010,
    F3_SLTU   = 3'b011,
    F3_XOR    = 3'b100,
    F3_SR     = 3'b101,
    F3_OR     = 3'b110,
    F3_AND    = 3'b111
  } f3_e;

  localparam int unsigned F7_ALT_BIT = 5;
endpackage

// File: rtl/int_alu_opsel.sv
module int_alu_opsel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 12
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  always_comb begin
    if (use_imm_i) op_b_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    else           op_b_o = rs2_i;
  end

  // upper bits in imm mode must agree with the immediate sign
  always_comb begin
    if (use_imm_i)
      assert_imm_sext_R11: assert (op_b_o[DATA_W-1] == imm_i[IMM_W-1] && op_b_o[IMM_W-1:0] == imm_i);
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] rev_in, rev_out;
  logic              fill;

  // left shift = right shift of the bit-reversed value
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = val_i[DATA_W-1-i];
    assign rev_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign fill     = arith_i & ~left_i & val_i[DATA_W-1];
  assign stage[0] = left_i ? rev_in : val_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{D{fill}}, stage[s][DATA_W-1:D]} : stage[s];
  end

  assign res_o = left_i ? rev_out : stage[SH_W];

  always_comb begin
    if (amt_i == '0) assert_zero_shift_R5: assert (res_o == val_i);
  end
endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              lt_s_o,
  output logic              lt_u_o
);
  assign lt_u_o = a_i < b_i;
  assign lt_s_o = (a_i[DATA_W-1] != b_i[DATA_W-1]) ? a_i[DATA_W-1] : lt_u_o;

  // signed and unsigned only disagree when the sign bits differ
  always_comb begin
    if (a_i[DATA_W-1] == b_i[DATA_W-1]) assert_sign_agree_R9: assert (lt_s_o == lt_u_o);
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 12,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [2:0]        func3_i,
  input  logic [6:0]        func7_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              out_valid_o
);
  logic [DATA_W-1:0] op_b, sum, sh_res, next_res;
  logic              alt, do_sub, lt_s, lt_u;
  f3_e               f3;

  assign f3     = f3_e'(func3_i);
  assign alt    = func7_i[F7_ALT_BIT];
  assign do_sub = alt & ~use_imm_i;

  int_alu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm_i (use_imm_i),
    .rs2_i     (rs2_i),
    .imm_i     (imm_i),
    .op_b_o    (op_b)
  );

  int_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .val_i   (rs1_i),
    .amt_i   (op_b[SH_W-1:0]),
    .left_i  (f3 == F3_SLL),
    .arith_i (alt),
    .res_o   (sh_res)
  );

  int_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i    (rs1_i),
    .b_i    (op_b),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign sum = rs1_i + (do_sub ? ~op_b : op_b) + DATA_W'(do_sub);

  always_comb begin
    unique case (f3)
      F3_ADDSUB: next_res = sum;
      F3_SLL,
      F3_SR:     next_res = sh_res;
      F3_SLT:    next_res = DATA_W'(lt_s);
      F3_SLTU:   next_res = DATA_W'(lt_u);
      F3_XOR:    next_res = rs1_i ^ op_b;
      F3_OR:     next_res = rs1_i | op_b;
      F3_AND:    next_res = rs1_i & op_b;
      default:   next_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= next_res;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_valid_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  assert_slt_narrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (func3_i == F3_SLT || func3_i == F3_SLTU)) |=> result_o[DATA_W-1:1] == '0);
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  func3 = '0;
  logic [6:0]  func7 = '0;
  logic        use_imm = 1'b0;
  logic [31:0] rs1 = '0, rs2 = '0;
  logic [11:0] imm = '0;
  logic [31:0] result;
  logic        out_valid;

  int checks = 0, fails = 0;
  logic [31:0] exp_res = '0;
  logic        exp_valid = 1'b0;
  string       exp_tag = "R1";

  always #10 clk = ~clk;

  int_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .func3_i(func3),
    .func7_i(func7), .use_imm_i(use_imm), .rs1_i(rs1), .rs2_i(rs2),
    .imm_i(imm), .result_o(result), .out_valid_o(out_valid)
  );

  function automatic logic [31:0] model(input logic [2:0] f3, input logic [6:0] f7,
      input logic im, input logic [31:0] a, input logic [31:0] r2, input logic [11:0] iv);
    logic [31:0] b;
    int sh;
    b  = im ? {{20{iv[11]}}, iv} : r2;
    sh = int'(b % 32);
    case (f3)
      3'd0: return (!im && f7[5]) ? a - b : a + b;
      3'd1: return a << sh;
      3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      3'd3: return (a < b) ? 32'd1 : 32'd0;
      3'd4: return a ^ b;
      3'd5: return f7[5] ? $unsigned($signed(a) >>> sh) : a >> sh;
      3'd6: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f3, input logic [6:0] f7, input logic im);
    if (im) return "R11";
    if (f7 != 7'h00 && f7 != 7'h20) return "R12";
    case (f3)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd5: return f7[5] ? "R7" : "R6";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference, one cycle of latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res   <= '0;
      exp_tag   <= "R1";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_res <= model(func3, func7, use_imm, rs1, rs2, imm);
        exp_tag <= tag_of(func3, func7, use_imm);
      end else begin
        exp_tag <= "R3";
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (out_valid !== exp_valid) begin
      fails++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end
    checks++;
    if (result !== exp_res) begin
      fails++;
      $display("FAIL %s result actual=%08h expected=%08h", exp_tag, result, exp_res);
    end
  end

  task automatic issue(input logic [2:0] f3, input logic [6:0] f7, input logic im,
                       input logic [31:0] a, input logic [31:0] b, input logic [11:0] iv);
    @(posedge clk); #2;
    in_valid = 1'b1; func3 = f3; func7 = f7; use_imm = im; rs1 = a; rs2 = b; imm = iv;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    in_valid = 1'b0; rs1 = $urandom; rs2 = $urandom; func3 = 3'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle();
    issue(3'd0, 7'h00, 0, 32'hFFFF_FFFF, 32'd1, 0);        // R4 wrap add
    issue(3'd0, 7'h20, 0, 32'd0, 32'd1, 0);                // R4 sub borrow
    issue(3'd1, 7'h00, 0, 32'h8000_0001, 32'd31, 0);       // R5
    issue(3'd1, 7'h00, 0, 32'h1234_5678, 32'd32, 0);       // R5 amount wraps to 0
    issue(3'd5, 7'h00, 0, 32'h8000_0000, 32'd31, 0);       // R6
    issue(3'd5, 7'h20, 0, 32'h8000_0000, 32'd31, 0);       // R7
    issue(3'd5, 7'h20, 0, 32'h4000_0000, 32'd4, 0);        // R7 positive
    issue(3'd2, 7'h00, 0, 32'hFFFF_FFFF, 32'd1, 0);        // R8 -1 < 1
    issue(3'd3, 7'h00, 0, 32'hFFFF_FFFF, 32'd1, 0);        // R9
    issue(3'd4, 7'h00, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 0);// R10
    issue(3'd6, 7'h00, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 0);
    issue(3'd7, 7'h00, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 0);
    issue(3'd0, 7'h20, 1, 32'd10, 32'hDEAD_BEEF, 12'h800); // R11 -2048, no sub
    issue(3'd0, 7'h00, 1, 32'd10, 32'd5, 12'h7FF);         // R11 2047
    issue(3'd2, 7'h00, 1, 32'd5, 32'd0, 12'hFFF);          // R11 slti vs -1
    issue(3'd0, 7'h5F, 0, 32'd7, 32'd3, 0);                // R12 extra func7 bits
    issue(3'd5, 7'h1F, 0, 32'h8000_0000, 32'd1, 0);        // R12
    idle(); idle();                                         // R3 hold
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 3 == 0) idle();
      else issue(3'($urandom), ($urandom % 2) ? 7'h20 : 7'($urandom),
                 1'($urandom % 4 == 0), $urandom, ($urandom % 2) ? 32'($urandom % 40) : $urandom,
                 12'($urandom));
    end
    idle(); idle();
    #2 rst_n = 1'b0;                                        // R1 again mid-run
    @(negedge clk); @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule